// File: doc/BRIEF.md
# Cascadable Nibble Column Capture Chain

This block is the input stage of an 80-column display segment driver. A controller presents 4-bit display data together with a slow shift clock. On every falling edge of that shift clock, while the block holds the enable token, the nibble is written into the next four columns of an 80-bit row register. After the twentieth nibble the block marks itself full, stops taking data and raises its enable output. That output feeds the enable input of the next driver in a cascade, so a chain of drivers fills one wide row from a single shared bus with no per-driver select lines.

A direction input sets two things. It chooses which of the two enable pins is the token input and which is the token output, and it mirrors the column mapping so that the row can be loaded from either end. The falling edge of a line-latch pulse rewinds the nibble slot to zero and drops the enable output. The row contents stay in place and are overwritten nibble by nibble as the next row arrives. The shift clock and latch pulse are slow pins that a fast system clock samples, and their falling edges are found in logic.

Top module: `nibble_column_capture`

## Requirements
- R1: A nibble is written only on a falling edge of the shift clock. A rising edge, or a shift clock that is held at either level, writes nothing.
- R2: Twenty accepted falling edges fill all 80 columns. The enable output is low after 19 accepted nibbles and high once the 20th has been written.
- R3: With direction low, pin A is the enable input and pin B drives the enable output (pin B output-enable 1, pin A output-enable 0). Nibble k (k = 0..19) goes to columns 4k..4k+3, with data bit 3 at column 4k and bit 0 at column 4k+3.
- R4: With direction high, the pin roles swap (pin A drives, pin B is the input) and the mapping is mirrored. Data bit b of nibble k lands at column 79 - (4k + 3 - b), so bit 3 of the first nibble is at column 79 and bit 0 of the last nibble is at column 0.
- R5: A falling edge of the line-latch pulse drops the enable output and sends the next accepted nibble to slot 0.
- R6: While the selected enable input is low, shift edges write nothing and the slot does not advance. Loading resumes at the same slot once the input goes high.
- R7: After the 20th nibble, further shift edges are ignored until the next latch falling edge.
- R8: The row register keeps its contents across a latch pulse. Each column changes only when its own nibble of the new row is written.
- R9: When the latch and the shift clock fall in the same sampled cycle, the latch takes effect and that nibble is discarded.
- R10: After reset the row is all zeros, the enable output is low and the pins take the direction-low roles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| shift_clk_i | input | 1 | Slow shift clock; data is taken on its falling edge |
| latch_i | input | 1 | Line-latch pulse; its falling edge rewinds the chain |
| data_i | input | 4 | Display data nibble, bit 3 first in column order |
| dir_i | input | 1 | Direction: 0 = pin A in, forward map; 1 = pin B in, mirrored map |
| chain_a_i | input | 1 | Level seen on enable pin A |
| chain_b_i | input | 1 | Level seen on enable pin B |
| chain_a_o | output | 1 | Value driven on enable pin A |
| chain_a_oe | output | 1 | Output enable of pin A |
| chain_b_o | output | 1 | Value driven on enable pin B |
| chain_b_oe | output | 1 | Output enable of pin B |
| row_o | output | 80 | Captured display row, column 0 at bit 0 |

## Verification
A row rewind and a nibble write can fall in the same sampled cycle. The bench provokes this by taking the shift clock and the latch pulse low on the same system-clock edge, part way through a row. It then loads a fresh row of 20 nibbles. The collision is judged correct only if the fresh row lands in the forward or mirrored map starting at slot 0, and the enable output stays low after the 19th fresh nibble and rises after the 20th. A discarded nibble that had been written, or one that had advanced the slot, would shift every later column.

// File: rtl/nibcap_pkg.sv
package nibcap_pkg;
  localparam int unsigned COLS_DEF = 80;
  localparam int unsigned NIB_DEF  = 4;

  // slot index (nibble number) that owns column c for a given direction
  function automatic int unsigned slot_of(int unsigned c, int unsigned cols,
                                          int unsigned nib, logic rev);
    int unsigned m;
    m = rev ? (cols - 1 - c) : c;
    return m / nib;
  endfunction

  // data bit of the nibble that lands in column c
  function automatic int unsigned bit_of(int unsigned c, int unsigned cols,
                                         int unsigned nib, logic rev);
    int unsigned m;
    m = rev ? (cols - 1 - c) : c;
    return nib - 1 - (m % nib);
  endfunction
endpackage

// File: rtl/nibcap_sync.sv
module nibcap_sync #(
  parameter int unsigned NIB = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_clk_i,
  input  logic           latch_i,
  input  logic [NIB-1:0] data_i,
  input  logic           dir_i,
  input  logic           chain_a_i,
  input  logic           chain_b_i,
  output logic           sck_fall,
  output logic           lat_fall,
  output logic [NIB-1:0] nib_s,
  output logic           dir_s,
  output logic           ein
);
  logic sck_s, sck_d, lat_s, lat_d, ea_s, eb_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_s <= 1'b0;
      sck_d <= 1'b0;
      lat_s <= 1'b0;
      lat_d <= 1'b0;
      nib_s <= '0;
      dir_s <= 1'b0;
      ea_s  <= 1'b0;
      eb_s  <= 1'b0;
    end else begin
      sck_s <= shift_clk_i;
      sck_d <= sck_s;
      lat_s <= latch_i;
      lat_d <= lat_s;
      nib_s <= data_i;
      dir_s <= dir_i;
      ea_s  <= chain_a_i;
      eb_s  <= chain_b_i;
    end
  end

  assign sck_fall = sck_d & ~sck_s;
  assign lat_fall = lat_d & ~lat_s;
  assign ein      = dir_s ? eb_s : ea_s;

  a_r1_fall_is_edge: assert property (@(posedge clk) disable iff (rst)
    sck_fall |=> !sck_fall);
endmodule

// File: rtl/nibcap_ptr.sv
module nibcap_ptr #(
  parameter int unsigned SLOTS = 20,
  parameter int unsigned PW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sck_fall,
  input  logic          lat_fall,
  input  logic          ein,
  output logic [PW-1:0] ptr,
  output logic          done,
  output logic          cap
);
  localparam logic [PW-1:0] LAST = PW'(SLOTS - 1);

  logic active;
  assign active = ein & ~done;
  assign cap    = sck_fall & active & ~lat_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      done <= 1'b0;
    end else if (lat_fall) begin
      ptr  <= '0;
      done <= 1'b0;
    end else if (cap) begin
      if (ptr == LAST) done <= 1'b1;
      else             ptr  <= ptr + 1'b1;
    end
  end

  a_r2_ptr_range: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST);
  a_r5_latch_rewinds: assert property (@(posedge clk) disable iff (rst)
    lat_fall |=> (ptr == '0) && !done);
  a_r7_full_sticks: assert property (@(posedge clk) disable iff (rst)
    (done && !lat_fall) |=> done && $stable(ptr));
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!ein && !lat_fall) |=> $stable(ptr) && $stable(done));
  a_r9_latch_wins: assert property (@(posedge clk) disable iff (rst)
    (lat_fall && sck_fall) |=> ptr == '0);
endmodule

// File: rtl/nibcap_row.sv
module nibcap_row
  import nibcap_pkg::*;
#(
  parameter int unsigned COLS = 80,
  parameter int unsigned NIB  = 4,
  parameter int unsigned PW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap,
  input  logic            dir,
  input  logic [PW-1:0]   ptr,
  input  logic [NIB-1:0]  nib,
  output logic [COLS-1:0] row
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam logic [PW-1:0] SF = PW'(slot_of(c, COLS, NIB, 1'b0));
    localparam logic [PW-1:0] SR = PW'(slot_of(c, COLS, NIB, 1'b1));
    localparam int unsigned   BF = bit_of(c, COLS, NIB, 1'b0);
    localparam int unsigned   BR = bit_of(c, COLS, NIB, 1'b1);

    logic hit;
    assign hit = cap && (ptr == (dir ? SR : SF));

    always_ff @(posedge clk) begin
      if (rst)      row[c] <= 1'b0;
      else if (hit) row[c] <= dir ? nib[BR] : nib[BF];
    end
  end

  a_r8_no_write_keeps: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(row));
endmodule

// File: rtl/nibble_column_capture.sv
module nibble_column_capture
  import nibcap_pkg::*;
#(
  parameter int unsigned COLS = COLS_DEF,
  parameter int unsigned NIB  = NIB_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_clk_i,
  input  logic            latch_i,
  input  logic [NIB-1:0]  data_i,
  input  logic            dir_i,
  input  logic            chain_a_i,
  input  logic            chain_b_i,
  output logic            chain_a_o,
  output logic            chain_a_oe,
  output logic            chain_b_o,
  output logic            chain_b_oe,
  output logic [COLS-1:0] row_o
);
  localparam int unsigned SLOTS = COLS / NIB;
  localparam int unsigned PW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic           sck_fall, lat_fall, dir_s, ein, done, cap;
  logic [NIB-1:0] nib_s, nib_g;
  logic [PW-1:0]  ptr;

  nibcap_sync #(.NIB(NIB)) u_sync (
    .clk(clk), .rst(rst), .shift_clk_i(shift_clk_i), .latch_i(latch_i),
    .data_i(data_i), .dir_i(dir_i), .chain_a_i(chain_a_i),
    .chain_b_i(chain_b_i), .sck_fall(sck_fall), .lat_fall(lat_fall),
    .nib_s(nib_s), .dir_s(dir_s), .ein(ein)
  );

  nibcap_ptr #(.SLOTS(SLOTS), .PW(PW)) u_ptr (
    .clk(clk), .rst(rst), .sck_fall(sck_fall), .lat_fall(lat_fall),
    .ein(ein), .ptr(ptr), .done(done), .cap(cap)
  );

  // idle gating: the data bus seen by the row is forced low without a capture
  assign nib_g = cap ? nib_s : '0;

  nibcap_row #(.COLS(COLS), .NIB(NIB), .PW(PW)) u_row (
    .clk(clk), .rst(rst), .cap(cap), .dir(dir_s), .ptr(ptr),
    .nib(nib_g), .row(row_o)
  );

  assign chain_a_o  = done;
  assign chain_b_o  = done;
  assign chain_a_oe = dir_s;
  assign chain_b_oe = ~dir_s;

  a_r2_token_from_capture: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(cap));
  a_r3_one_driver: assert property (@(posedge clk) disable iff (rst)
    $countones({chain_a_oe, chain_b_oe}) == 1);
endmodule

// File: tb/nibble_column_capture_tb.sv
module nibble_column_capture_tb;
  localparam int COLS = 80;
  localparam int NIB  = 4;
  localparam int SLOTS = COLS / NIB;

  logic clk = 1'b0;
  logic rst, sck, lat, dir, ea, eb;
  logic [NIB-1:0]  dat;
  logic            a_o, a_oe, b_o, b_oe;
  logic [COLS-1:0] row;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [COLS-1:0] exp_row;
  int  exp_ptr;
  bit  exp_full;

  always #2 clk = ~clk;

  nibble_column_capture u_dut (
    .clk(clk), .rst(rst), .shift_clk_i(sck), .latch_i(lat), .data_i(dat),
    .dir_i(dir), .chain_a_i(ea), .chain_b_i(eb), .chain_a_o(a_o),
    .chain_a_oe(a_oe), .chain_b_o(b_o), .chain_b_oe(b_oe), .row_o(row)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_vec(string req, logic [COLS-1:0] act, logic [COLS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // bench model of one accepted nibble
  task automatic model_nib(logic [NIB-1:0] n);
    int cf;
    if (!exp_full) begin
      for (int b = 0; b < NIB; b++) begin
        cf = NIB * exp_ptr + (NIB - 1 - b);
        exp_row[dir ? (COLS - 1 - cf) : cf] = n[b];
      end
      if (exp_ptr == SLOTS - 1) exp_full = 1'b1;
      else exp_ptr++;
    end
  endtask

  function automatic bit en_now();
    return dir ? eb : ea;
  endfunction

  task automatic shift(logic [NIB-1:0] n);
    dat = n; sck = 1'b1; tick(2);
    sck = 1'b0; tick(2);
    if (en_now()) model_nib(n);
  endtask

  task automatic latch_pulse();
    lat = 1'b1; tick(2);
    lat = 1'b0; tick(2);
    exp_ptr = 0; exp_full = 1'b0;
  endtask

  task automatic set_en(bit v);
    if (dir) begin eb = v; ea = 1'b0; end
    else     begin ea = v; eb = 1'b0; end
  endtask

  function automatic logic eout();
    return dir ? a_o : b_o;
  endfunction

  task automatic load_row(string req, int n_nibs);
    for (int k = 0; k < n_nibs; k++) shift(4'($urandom));
  endtask

  initial begin
    void'($urandom(32'd1648));
    rst = 1'b1; sck = 1'b0; lat = 1'b0; dat = '0; dir = 1'b0; ea = 1'b0; eb = 1'b0;
    exp_row = '0; exp_ptr = 0; exp_full = 1'b0;
    tick(4);
    rst = 1'b0;
    tick(1);
    // R10 reset state
    chk_vec("R10 row after reset", row, '0);
    chk_bit("R10 enable out after reset", b_o, 1'b0);
    chk_bit("R10 pin B drives after reset", b_oe, 1'b1);
    chk_bit("R10 pin A input after reset", a_oe, 1'b0);

    // R1 rising edge only / held high: nothing written
    set_en(1'b1);
    dat = 4'hF; sck = 1'b1; tick(4);
    chk_vec("R1 rising edge writes nothing", row, exp_row);

    // R3 forward load, R2 token timing
    sck = 1'b0; tick(2); model_nib(4'hF);
    load_row("R3", SLOTS - 2);
    chk_bit("R2 enable out low after 19 nibbles", b_o, 1'b0);
    shift(4'h9);
    chk_bit("R2 enable out high after 20 nibbles", b_o, 1'b1);
    chk_vec("R3 forward mapping", row, exp_row);
    chk_bit("R3 first bit at column 0", row[0], 1'b1);

    // R7 extra shifts ignored
    begin
      logic [COLS-1:0] snap;
      snap = row;
      for (int k = 0; k < 5; k++) shift(4'($urandom));
      chk_vec("R7 extra shifts ignored", row, snap);
    end

    // R5 latch drops token, R8 row kept
    latch_pulse();
    chk_bit("R5 enable out after latch", b_o, 1'b0);
    chk_vec("R8 row kept across latch", row, exp_row);
    shift(4'h0);
    chk_vec("R8 only first nibble overwritten", row, exp_row);
    chk_vec("R5 next nibble in slot 0", row[3:0], 4'h0);

    // R4 mirrored, roles swapped
    latch_pulse();
    dir = 1'b1; set_en(1'b1); tick(2);
    chk_bit("R4 pin A drives", a_oe, 1'b1);
    chk_bit("R4 pin B input", b_oe, 1'b0);
    shift(4'h8);
    load_row("R4", SLOTS - 2);
    shift(4'h1);
    chk_vec("R4 mirrored mapping", row, exp_row);
    chk_bit("R4 last bit at column 0", row[0], 1'b1);
    chk_bit("R4 first bit at column 79", row[COLS-1], 1'b1);
    chk_bit("R4 enable out on pin A", a_o, 1'b1);

    // R6 enable low pauses loading
    latch_pulse();
    dir = 1'b0; set_en(1'b1); tick(2);
    load_row("R6", 10);
    set_en(1'b0);
    begin
      logic [COLS-1:0] snap;
      snap = row;
      for (int k = 0; k < 3; k++) shift(4'($urandom));
      chk_vec("R6 disabled shifts ignored", row, snap);
    end
    set_en(1'b1);
    load_row("R6", 9);
    chk_bit("R6 slot held while disabled", b_o, 1'b0);
    shift(4'h5);
    chk_vec("R6 resumed row", row, exp_row);
    chk_bit("R6 enable out after resume", b_o, 1'b1);

    // R9 latch and shift fall together
    latch_pulse();
    load_row("R9", 5);
    dat = 4'hA; sck = 1'b1; lat = 1'b1; tick(2);
    sck = 1'b0; lat = 1'b0; tick(2);
    exp_ptr = 0; exp_full = 1'b0;
    load_row("R9", SLOTS - 1);
    chk_bit("R9 enable out low after 19 fresh", b_o, 1'b0);
    shift(4'h3);
    chk_vec("R9 colliding nibble discarded", row, exp_row);
    chk_bit("R9 enable out after 20 fresh", b_o, 1'b1);

    // random rows, random direction
    for (int r = 0; r < 6; r++) begin
      latch_pulse();
      dir = 1'($urandom); set_en(1'b1); tick(2);
      load_row("R2", SLOTS + int'($urandom % 3));
      chk_vec(dir ? "R4 random mirrored row" : "R3 random forward row", row, exp_row);
      chk_bit("R2 random enable out", eout(), 1'b1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule